// File: doc/BRIEF.md
# 8-bit Arithmetic Unit with Condition-Code Update

This block is the arithmetic datapath of a small accumulator processor. On each issued operation it takes a primary operand, a secondary operand, a 3-bit operation select and the processor's current condition-code byte. One clock later it returns the 8-bit result, the updated condition-code byte and a strobe that marks them valid. It offers eight operations: add, add with carry, subtract, subtract with borrow, negate, increment, rotate left through carry, and test.

Each operation has its own rule for which flags it writes. Only addition computes half-carry. Negate and increment detect overflow by looking for the single result value that cannot be represented. Increment and test keep the incoming carry. The flags sit at fixed positions: carry at bit 0, overflow at bit 1, zero at bit 2, negative at bit 3 and half-carry at bit 5. Bits 4, 6 and 7 belong to the surrounding processor and pass straight through.

The instruction decoder issues an operation by raising `op_valid` with the operands and select for one cycle. It then writes back `res_out` and `cc_out` in the cycle where `res_valid` is high. While no operation is issued, the outputs hold their last values.

Top module: `alu_cc_core`

## Requirements
- R1: `res_valid` is high in exactly the cycle after a cycle where `op_valid` was high. `res_out` and `cc_out` carry that operation's outcome in the same cycle.
- R2: A synchronous active-high `rst` drives `res_out`, `cc_out` and `res_valid` to zero at the next rising edge, even if an operation is issued in that cycle.
- R3: While `op_valid` is low, `res_out` and `cc_out` keep their previous values and `res_valid` is low.
- R4: The flags are carry = bit 0, overflow = bit 1, zero = bit 2, negative = bit 3 and half-carry = bit 5. Bits 4, 6 and 7 of `cc_out` equal those of `cc_in` for every operation.
- R5: Add (`op_sel` 0) and add with carry (`op_sel` 1, which also adds `cc_in` bit 0) produce the low 8 bits of the sum. Carry is bit 8 of the 9-bit sum. Half-carry is bit 4 of (A xor B xor sum). Overflow is bit 7 of (A xor B xor sum) xor the new carry.
- R6: Subtract (`op_sel` 2) gives A − B. Subtract with borrow (`op_sel` 3) gives A − B − `cc_in` bit 0. Carry is set when A < B + borrow-in, compared in 9 bits. Overflow is bit 7 of (A xor B xor result) xor the new carry. Half-carry is unchanged.
- R7: Negate (`op_sel` 4) gives 256 − A. Carry is set when the result is nonzero. Overflow is set only for the result 0x80. Half-carry is unchanged.
- R8: Increment (`op_sel` 5) gives A + 1. Overflow is set only for the result 0x80. Carry and half-carry are unchanged.
- R9: Rotate left (`op_sel` 6) gives {A[6:0], `cc_in` bit 0}. Carry becomes the old A[7]. Overflow is the old A[7] xor the old A[6]. Half-carry is unchanged.
- R10: Test (`op_sel` 7) returns A unchanged as the result. It clears overflow and keeps carry and half-carry.
- R11: For every operation, zero is set exactly when the 8-bit result is 0, and negative equals result bit 7.
- R12: Negate, increment, rotate and test ignore operand B. Changing B does not change `res_out` or `cc_out` for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issues an operation this cycle |
| op_sel | input | 3 | Operation select (0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 negate, 5 increment, 6 rotate left, 7 test) |
| opnd_a | input | 8 | Primary operand |
| opnd_b | input | 8 | Secondary operand, used only by the add and subtract operations |
| cc_in | input | 8 | Current condition-code byte |
| res_out | output | 8 | Registered result |
| cc_out | output | 8 | Registered updated condition-code byte |
| res_valid | output | 1 | High for one cycle when the outputs carry a new operation |

## Verification
Every internal error in this block shows at the ports one cycle after the offending operation. The outputs come straight from a single register stage, so no state persists beyond that register. A wrong per-operation write mask shows as a flag that either keeps its `cc_in` value when it should change, or changes when it should be kept. Such errors only appear when the incoming flag differs from the computed one, so the stimulus deliberately sets and clears incoming carry, overflow and half-carry. Carry and overflow mistakes concentrate at the 0x7F/0x80 and 0xFF/0x00 boundaries, and at a borrow-in that pushes B + 1 past 8 bits; the vectors target these cases directly.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  localparam int unsigned DW  = 8;
  localparam int unsigned CCW = 8;

  // Condition-code bit positions (fixed by the surrounding processor)
  localparam int unsigned CC_C = 0;
  localparam int unsigned CC_V = 1;
  localparam int unsigned CC_Z = 2;
  localparam int unsigned CC_N = 3;
  localparam int unsigned CC_H = 5;

  // Bits owned by the processor, never written here
  localparam logic [CCW-1:0] CC_KEEP = 8'hD0;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_NEG = 3'd4,
    OP_INC = 3'd5,
    OP_ROL = 3'd6,
    OP_TST = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic h;
    logic v;
    logic c;
  } flg_t;

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_cc_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   res,
  output flg_t           flg
);

  localparam int unsigned HB = W / 2;
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

  logic [W:0]   ext_a;
  logic [W:0]   ext_b;
  logic [W:0]   cext;
  logic [W:0]   sum;
  logic [W-1:0] diff;
  logic         cuse;
  logic         borrow;
  logic         cin_top_add;
  logic         cin_top_sub;

  always_comb begin
    cuse   = ((op == OP_ADC) || (op == OP_SBC)) ? cin : 1'b0;
    ext_a  = {1'b0, a};
    ext_b  = {1'b0, b};
    cext   = {{W{1'b0}}, cuse};
    sum    = ext_a + ext_b + cext;
    diff   = a - b - cext[W-1:0];
    // borrow out: minuend below subtrahend plus borrow-in, in W+1 bits
    borrow = (ext_a < (ext_b + cext));
    // carry into the sign bit, recovered from operands and result
    cin_top_add = a[W-1] ^ b[W-1] ^ sum[W-1];
    cin_top_sub = a[W-1] ^ b[W-1] ^ diff[W-1];

    res = '0;
    flg = '0;
    unique case (op)
      OP_ADD, OP_ADC: begin
        res   = sum[W-1:0];
        flg.c = sum[W];
        flg.h = a[HB] ^ b[HB] ^ sum[HB];
        flg.v = cin_top_add ^ sum[W];
      end
      OP_SUB, OP_SBC: begin
        res   = diff;
        flg.c = borrow;
        flg.v = cin_top_sub ^ borrow;
      end
      OP_NEG: begin
        res   = {W{1'b0}} - a;
        flg.c = (res != '0);
        flg.v = (res == MIN_NEG);
      end
      OP_INC: begin
        res   = a + ONE;
        flg.v = (res == MIN_NEG);
      end
      default: begin
        res = a;
      end
    endcase
  end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_cc_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic           cin,
  output logic [W-1:0]   res,
  output flg_t           flg
);

  always_comb begin
    res = a;
    flg = '0;
    if (op == OP_ROL) begin
      res   = {a[W-2:0], cin};
      flg.c = a[W-1];
      flg.v = a[W-1] ^ a[W-2];
    end else begin
      // test: pass operand, overflow forced low
      res   = a;
      flg.v = 1'b0;
    end
  end

endmodule

// File: rtl/alu_flag_merge.sv
module alu_flag_merge
  import alu_cc_pkg::*;
#(
  parameter int unsigned W  = DW,
  parameter int unsigned CW = CCW
) (
  input  alu_op_e        op,
  input  logic [CW-1:0]  cc_in,
  input  logic [W-1:0]   res,
  input  flg_t           flg,
  output logic [CW-1:0]  cc_new
);

  logic wr_h;
  logic wr_c;

  // per-operation write enables; overflow, zero and negative always written
  always_comb begin
    wr_h = (op == OP_ADD) || (op == OP_ADC);
    wr_c = (op != OP_INC) && (op != OP_TST);
  end

  always_comb begin
    cc_new = cc_in;
    if (wr_h) cc_new[CC_H] = flg.h;
    if (wr_c) cc_new[CC_C] = flg.c;
    cc_new[CC_V] = flg.v;
    cc_new[CC_Z] = (res == '0);
    cc_new[CC_N] = res[W-1];
  end

endmodule

// File: rtl/alu_cc_core.sv
module alu_cc_core
  import alu_cc_pkg::*;
#(
  parameter int unsigned W  = DW,
  parameter int unsigned CW = CCW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [2:0]     op_sel,
  input  logic [W-1:0]   opnd_a,
  input  logic [W-1:0]   opnd_b,
  input  logic [CW-1:0]  cc_in,
  output logic [W-1:0]   res_out,
  output logic [CW-1:0]  cc_out,
  output logic           res_valid
);

  alu_op_e       op;
  logic [W-1:0]  ar_res;
  logic [W-1:0]  sh_res;
  flg_t          ar_flg;
  flg_t          sh_flg;
  logic          use_shift;
  logic [W-1:0]  nxt_res;
  flg_t          nxt_flg;
  logic [CW-1:0] nxt_cc;

  assign op = alu_op_e'(op_sel);

  alu_arith #(.W(W)) u_arith (
    .op  (op),
    .a   (opnd_a),
    .b   (opnd_b),
    .cin (cc_in[CC_C]),
    .res (ar_res),
    .flg (ar_flg)
  );

  alu_shift #(.W(W)) u_shift (
    .op  (op),
    .a   (opnd_a),
    .cin (cc_in[CC_C]),
    .res (sh_res),
    .flg (sh_flg)
  );

  always_comb begin
    use_shift = (op == OP_ROL) || (op == OP_TST);
    nxt_res   = use_shift ? sh_res : ar_res;
    nxt_flg   = use_shift ? sh_flg : ar_flg;
  end

  alu_flag_merge #(.W(W), .CW(CW)) u_merge (
    .op     (op),
    .cc_in  (cc_in),
    .res    (nxt_res),
    .flg    (nxt_flg),
    .cc_new (nxt_cc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out   <= '0;
      cc_out    <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_out <= nxt_res;
        cc_out  <= nxt_cc;
      end
    end
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);

  // R1
  idle_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !res_valid);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(res_out) && $stable(cc_out)));

  // R4
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> ((cc_out & CC_KEEP) == ($past(cc_in) & CC_KEEP)));

  // R8
  inc_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_sel == 3'(OP_INC))) |=> (cc_out[CC_C] == $past(cc_in[CC_C])));

  // R10
  tst_clear_v_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_sel == 3'(OP_TST))) |=> !cc_out[CC_V]);

  // R11
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (cc_out[CC_Z] == (res_out == '0)));

  // R11
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (cc_out[CC_N] == res_out[W-1]));

endmodule

// File: tb/alu_cc_core_tb.sv
module alu_cc_core_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic [2:0] op_sel;
  logic [7:0] opnd_a;
  logic [7:0] opnd_b;
  logic [7:0] cc_in;
  logic [7:0] res_out;
  logic [7:0] cc_out;
  logic       res_valid;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  alu_cc_core u_dut (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_sel    (op_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .cc_in     (cc_in),
    .res_out   (res_out),
    .cc_out    (cc_out),
    .res_valid (res_valid)
  );

  // {op, A, B, cc_in, expected result, expected cc}
  localparam int NV = 20;
  localparam logic [42:0] VECS [NV] = '{
    {3'd0, 8'h0F, 8'h01, 8'h00, 8'h10, 8'h20},
    {3'd0, 8'h7F, 8'h01, 8'h00, 8'h80, 8'h2A},
    {3'd0, 8'hFF, 8'h01, 8'hD0, 8'h00, 8'hF5},
    {3'd1, 8'h10, 8'h20, 8'h21, 8'h31, 8'h00},
    {3'd1, 8'h80, 8'h7F, 8'h01, 8'h00, 8'h25},
    {3'd2, 8'h10, 8'h20, 8'h20, 8'hF0, 8'h29},
    {3'd2, 8'h80, 8'h01, 8'h00, 8'h7F, 8'h02},
    {3'd2, 8'h05, 8'h05, 8'h01, 8'h00, 8'h04},
    {3'd3, 8'h05, 8'h05, 8'h01, 8'hFF, 8'h09},
    {3'd3, 8'h00, 8'hFF, 8'h01, 8'h00, 8'h05},
    {3'd4, 8'h01, 8'hAA, 8'h00, 8'hFF, 8'h09},
    {3'd4, 8'h80, 8'hAA, 8'h00, 8'h80, 8'h0B},
    {3'd4, 8'h00, 8'hAA, 8'h01, 8'h00, 8'h04},
    {3'd5, 8'h7F, 8'hAA, 8'h01, 8'h80, 8'h0B},
    {3'd5, 8'hFF, 8'hAA, 8'h03, 8'h00, 8'h05},
    {3'd6, 8'h80, 8'hAA, 8'h00, 8'h00, 8'h07},
    {3'd6, 8'h41, 8'hAA, 8'h01, 8'h83, 8'h0A},
    {3'd6, 8'hC0, 8'hAA, 8'h20, 8'h80, 8'h29},
    {3'd7, 8'h00, 8'hAA, 8'h03, 8'h00, 8'h05},
    {3'd7, 8'h90, 8'hAA, 8'hF2, 8'h90, 8'hF8}
  };

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R5";
      3'd2, 3'd3: return "R6";
      3'd4:       return "R7";
      3'd5:       return "R8";
      3'd6:       return "R9";
      default:    return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [7:0] cc);
    op_valid = 1'b1;
    op_sel   = op;
    opnd_a   = a;
    opnd_b   = b;
    cc_in    = cc;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst      = 1'b1;
    op_valid = 1'b0;
    op_sel   = 3'd0;
    opnd_a   = 8'h00;
    opnd_b   = 8'h00;
    cc_in    = 8'h00;
    repeat (3) @(negedge clk);

    // R2: reset state
    chk("R2", "reset res_out", res_out, 8'h00);
    chk("R2", "reset cc_out", cc_out, 8'h00);
    chk("R2", "reset res_valid", {7'd0, res_valid}, 8'h00);
    rst = 1'b0;

    // vector walk, back to back
    for (int i = 0; i < NV; i++) begin
      issue(VECS[i][42:40], VECS[i][39:32], VECS[i][31:24], VECS[i][23:16]);
      @(negedge clk);
      chk(tag_of(VECS[i][42:40]), $sformatf("vec %0d result", i), res_out, VECS[i][15:8]);
      // R4 R11 flag positions, pass-through bits, zero and negative
      chk(tag_of(VECS[i][42:40]), $sformatf("vec %0d cc R4 R11", i), cc_out, VECS[i][7:0]);
      chk("R1", $sformatf("vec %0d res_valid", i), {7'd0, res_valid}, 8'h01);
    end

    // R3: idle cycles hold outputs while inputs change
    op_valid = 1'b0;
    op_sel   = 3'd0;
    opnd_a   = 8'h33;
    opnd_b   = 8'h44;
    cc_in    = 8'h0F;
    @(negedge clk);
    chk("R1", "idle res_valid low", {7'd0, res_valid}, 8'h00);
    opnd_a = 8'h01;
    @(negedge clk);
    chk("R3", "hold res_out", res_out, 8'h90);
    chk("R3", "hold cc_out", cc_out, 8'hF8);

    // R12: B does not affect unary operations
    issue(3'd4, 8'h01, 8'h55, 8'h00);
    @(negedge clk);
    chk("R12", "neg with other B result", res_out, 8'hFF);
    chk("R12", "neg with other B cc", cc_out, 8'h09);
    issue(3'd6, 8'h41, 8'h00, 8'h01);
    @(negedge clk);
    chk("R12", "rol with B zero result", res_out, 8'h83);
    chk("R12", "rol with B zero cc", cc_out, 8'h0A);
    issue(3'd5, 8'h7F, 8'hFF, 8'h01);
    @(negedge clk);
    chk("R12", "inc with B ff cc", cc_out, 8'h0B);

    // R4: pass-through bits with add that clears all owned flags
    issue(3'd0, 8'h01, 8'h01, 8'hFF);
    @(negedge clk);
    chk("R4", "add keep bits 7 6 4", cc_out, 8'hD0);

    // R2: reset wins over an issued operation
    issue(3'd0, 8'h12, 8'h34, 8'h00);
    rst = 1'b1;
    @(negedge clk);
    chk("R2", "mid reset res_out", res_out, 8'h00);
    chk("R2", "mid reset cc_out", cc_out, 8'h00);
    chk("R2", "mid reset res_valid", {7'd0, res_valid}, 8'h00);
    rst      = 1'b0;
    op_valid = 1'b0;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule